// File: doc/BRIEF.md
# Flexible-Resolution Sub-DAC Lane Controller

This block is the digital front end of a converter assembled from a row of identical 12-bit sub-converters (lanes) whose analog outputs are summed. From one input word and a resolution setting it works out, for every lane, a 12-bit code. Each code is one of three things: the all-ones code, the all-zeros code, or the low 12 bits of the input word. The lanes are ranked 0 upward. The bits of the input word above the low 12 act as a pointer that picks the one lane that converts the low bits. Every lane ranked below the pointer is driven to all-ones. Every lane ranked above it is driven to all-zeros.

The resolution setting chooses how many lanes take part. In N-bit mode, 2^(N-12) lanes are active and the rest are held at zero. This gives 12 to 16 bits of resolution from the same set of lanes. All lane codes are registered together, so the whole set changes on a single clock edge.

Top module: `flexdac_ctrl`

## Requirements
- R1: While `rst_n` is low, every lane code is 0.
- R2: Exactly one lane carries `din[11:0]`. Its index is the pointer `p`, which is `din[15:12]` with only its low `m` bits kept, where `m` is the effective mode.
- R3: Every lane with an index below `p` outputs 12'hFFF.
- R4: Every lane with an index above `p` outputs 12'h000.
- R5: `res_sel` encodes the resolution as 12+`res_sel` bits for the values 0 to 4. The values 5 to 7 act as 4 (16-bit mode).
- R6: In effective mode `m`, lanes 2^m to 15 output 12'h000 whatever the input.
- R7: Input bits `din[15:12+m]` above the selected resolution have no effect on any lane code.
- R8: Lane codes follow the inputs with exactly one cycle of latency. All lanes update on the same rising edge.
- R9: A change of `res_sel` applies to the sample registered on the next rising edge, with no extra delay.
- R10: With `res_sel`=0, lane 0 outputs `din[11:0]` and lanes 1 to 15 output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 16 | Input word: the low 12 bits are lane data, the upper 4 bits are the pointer |
| res_sel | input | 3 | Resolution select, 12+res_sel bits, values above 4 act as 4 |
| lane_codes | output | 192 | Registered codes, lane k at bits [12k+11:12k] |

## Verification
The assertions assume that `din` and `res_sel` are stable around each rising edge and that reset is held for at least one edge. The bench meets this by changing inputs only on the falling edge. Every `res_sel` value is taken as legal, so the bench also drives the values 5 to 7 to exercise the clamp to 16-bit mode. The bench reads lane codes on the falling edge after each sample edge. It also reads them once before that edge, to show that nothing changes early.

// File: rtl/flexdac_pkg.sv
package flexdac_pkg;

   // control pair for one lane, produced by the pointer decoder
   typedef struct packed {
      logic fill;   // drive all-ones
      logic sel;    // drive the data bits
   } lane_ctl_t;

   // clamp a resolution select to the largest supported mode
   function automatic int unsigned clamp_mode(input int unsigned sel_val,
                                              input int unsigned mode_max);
      return (sel_val > mode_max) ? mode_max : sel_val;
   endfunction

endpackage

// File: rtl/flexdac_ptr_decode.sv
module flexdac_ptr_decode
   import flexdac_pkg::*;
#(
   parameter int NUM_SUB = 16,
   parameter int MODE_W  = 3,
   localparam int PTR_W  = $clog2(NUM_SUB)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PTR_W-1:0]   ptr_raw,
   input  logic [MODE_W-1:0]  res_sel,
   output lane_ctl_t          ctl [NUM_SUB]
);

   localparam int MODE_MAX = PTR_W;

   logic [MODE_W-1:0] eff_mode;
   logic [PTR_W-1:0]  ptr_mask;
   logic [PTR_W-1:0]  ptr;
   logic [NUM_SUB-1:0] active;
   logic [NUM_SUB-1:0] fill_v;
   logic [NUM_SUB-1:0] sel_v;

   always_comb begin
      eff_mode = MODE_W'(clamp_mode(int'(res_sel), MODE_MAX));
   end

   // keep only the pointer bits that belong to the selected resolution
   generate
      for (genvar k = 0; k < PTR_W; k++) begin : g_mask
         assign ptr_mask[k] = (MODE_W'(k) < eff_mode);
      end
   endgenerate

   assign ptr = ptr_raw & ptr_mask;

   generate
      for (genvar i = 0; i < NUM_SUB; i++) begin : g_lane
         assign active[i]   = ((32'(i) >> eff_mode) == 32'd0);
         assign fill_v[i]   = active[i] && (PTR_W'(i) < ptr);
         assign sel_v[i]    = (PTR_W'(i) == ptr);
         assign ctl[i].fill = fill_v[i];
         assign ctl[i].sel  = sel_v[i];
      end
   endgenerate

   AST_ONE_DATA_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_v) == 1);                                          // R2
   AST_FILL_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_v & (fill_v + 1'b1)) == '0);                                // R3
   AST_SEL_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_v & ~active) == '0);                                         // R6
   AST_FILL_BELOW_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_v & sel_v) == '0);                                          // R4

endmodule

// File: rtl/flexdac_lane.sv
module flexdac_lane
   import flexdac_pkg::*;
#(
   parameter int SUB_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lane_ctl_t        ctl,
   input  logic [SUB_W-1:0] data,
   output logic [SUB_W-1:0] code_q
);

   logic [SUB_W-1:0] code_d;

   always_comb begin
      if (ctl.sel)       code_d = data;
      else if (ctl.fill) code_d = '1;
      else               code_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_d;
   end

endmodule

// File: rtl/flexdac_ctrl.sv
module flexdac_ctrl
   import flexdac_pkg::*;
#(
   parameter int SUB_W   = 12,
   parameter int NUM_SUB = 16,
   parameter int MODE_W  = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [SUB_W+$clog2(NUM_SUB)-1:0] din,
   input  logic [MODE_W-1:0]                res_sel,
   output logic [NUM_SUB*SUB_W-1:0]         lane_codes
);

   localparam int PTR_W = $clog2(NUM_SUB);

   generate
      if (SUB_W < 1) begin : g_bad_width
         $error("SUB_W must be at least 1");
      end
      if (NUM_SUB < 2 || (1 << PTR_W) != NUM_SUB) begin : g_bad_count
         $error("NUM_SUB must be a power of two, at least 2");
      end
      if ((1 << MODE_W) <= PTR_W) begin : g_bad_mode
         $error("MODE_W too narrow for the largest mode");
      end
   endgenerate

   lane_ctl_t ctl [NUM_SUB];

   flexdac_ptr_decode #(
      .NUM_SUB (NUM_SUB),
      .MODE_W  (MODE_W)
   ) i_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr_raw (din[SUB_W +: PTR_W]),
      .res_sel (res_sel),
      .ctl     (ctl)
   );

   generate
      for (genvar i = 0; i < NUM_SUB; i++) begin : g_lanes
         flexdac_lane #(.SUB_W(SUB_W)) i_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl    (ctl[i]),
            .data   (din[SUB_W-1:0]),
            .code_q (lane_codes[i*SUB_W +: SUB_W])
         );
      end

      for (genvar i = 1; i < NUM_SUB; i++) begin : g_chk_order
         AST_BELOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_codes[i*SUB_W +: SUB_W] != '0)
               |-> (lane_codes[(i-1)*SUB_W +: SUB_W] == '1));           // R3
      end
   endgenerate

   AST_BASE_MODE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sel == '0) |=> (lane_codes[SUB_W-1:0] == $past(din[SUB_W-1:0]))); // R10
   AST_BASE_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_sel == '0) |=> (lane_codes[NUM_SUB*SUB_W-1:SUB_W] == '0));   // R6

endmodule

// File: tb/test_flexdac_ctrl.sv
module test_flexdac_ctrl;

   localparam int SUB_W = 12;
   localparam int NSUB  = 16;
   localparam int TOTW  = SUB_W * NSUB;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [15:0]     din = '0;
   logic [2:0]      res_sel = '0;
   logic [TOTW-1:0] lane_codes;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   flexdac_ctrl i_flexdac_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .din        (din),
      .res_sel    (res_sel),
      .lane_codes (lane_codes)
   );

   // reference built from the requirement text
   function automatic logic [TOTW-1:0] model(input logic [15:0] w, input logic [2:0] rs);
      logic [TOTW-1:0] v = '0;
      int m = (rs > 4) ? 4 : int'(rs);
      int p = int'(w[15:12]) % (1 << m);
      for (int i = 0; i < NSUB; i++) begin
         if (i >= (1 << m))  v[i*SUB_W +: SUB_W] = 12'h000;
         else if (i < p)     v[i*SUB_W +: SUB_W] = 12'hFFF;
         else if (i == p)    v[i*SUB_W +: SUB_W] = w[11:0];
         else                v[i*SUB_W +: SUB_W] = 12'h000;
      end
      return v;
   endfunction

   task automatic check(input string req, input logic [TOTW-1:0] act, input logic [TOTW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // drive on falling edge, sample on the following falling edge
   task automatic apply(input logic [15:0] w, input logic [2:0] rs);
      @(negedge clk);
      din = w;
      res_sel = rs;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      din = 16'hF5A5;
      res_sel = 3'd4;
      repeat (3) @(negedge clk);
      check("R1 reset", lane_codes, '0);
      rst_n = 1'b1;
   endtask

   task automatic t_base_mode();
      apply(16'h0ABC, 3'd0);
      check("R10 base mode", lane_codes, model(16'h0ABC, 3'd0));
      check("R10 lane0 data", {180'd0, lane_codes[11:0]}, {180'd0, 12'hABC});
      apply(16'hF123, 3'd0);
      check("R7 upper bits ignored 12b", lane_codes, model(16'h0123, 3'd0));
   endtask

   task automatic t_sweep_full();
      for (int p = 0; p < 16; p++) begin
         logic [15:0] w = {4'(p), 12'(12'h3C5 + p)};
         apply(w, 3'd4);
         check($sformatf("R2 R3 R4 ptr=%0d", p), lane_codes, model(w, 3'd4));
      end
      apply(16'hF000, 3'd4);
      check("R3 top lane data zero", lane_codes, {12'h000, {15{12'hFFF}}});
   endtask

   task automatic t_modes();
      for (int m = 1; m < 4; m++) begin
         logic [15:0] w = 16'hF7E1;
         apply(w, 3'(m));
         check($sformatf("R6 R7 mode=%0d", m), lane_codes, model(w, 3'(m)));
      end
      apply(16'hD001, 3'd1);
      check("R7 mode1 ptr=1", lane_codes, {{14{12'h000}}, 12'h001, 12'hFFF});
   endtask

   task automatic t_clamp();
      for (int rs = 5; rs < 8; rs++) begin
         apply(16'hB456, 3'(rs));
         check($sformatf("R5 sel=%0d", rs), lane_codes, model(16'hB456, 3'd4));
      end
   endtask

   task automatic t_latency();
      logic [TOTW-1:0] prev;
      apply(16'h2111, 3'd4);
      prev = lane_codes;
      @(negedge clk);
      din = 16'h9222;
      res_sel = 3'd4;
      @(posedge clk);
      #1;
      check("R8 updated after one edge", lane_codes, model(16'h9222, 3'd4));
      @(negedge clk);
      din = 16'h4333;
      #2;
      check("R8 no early update", lane_codes, model(16'h9222, 3'd4));
      check("R8 changed from prior", {191'd0, prev != lane_codes}, {191'd0, 1'b1});
   endtask

   task automatic t_mode_switch();
      apply(16'hC777, 3'd4);
      apply(16'hC777, 3'd2);
      check("R9 mode switch next sample", lane_codes, model(16'hC777, 3'd2));
      apply(16'hC777, 3'd3);
      check("R9 mode switch back up", lane_codes, model(16'hC777, 3'd3));
   endtask

   initial begin
      t_reset();
      t_base_mode();
      t_sweep_full();
      t_modes();
      t_clamp();
      t_latency();
      t_mode_switch();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule